// File: doc/BRIEF.md
# Restart Program Counter Unit

This block supplies instruction fetch addresses for a five-stage pipeline that has no hardware interlocks. Every accepted fetch advances the word-addressed PC by one. A taken branch leaves exactly one delay slot: the address right after the branch fetch is still fetched in sequence, and the held target follows it. Only one target can be held at a time.

The unit records the addresses of the most recent fetches in a short history. When a fault or interrupt arrives, the unit redirects fetch to a single handler entry address. It remembers the address that was being fetched and any target still held, and it freezes the history so the handler can read it. A return-from-exception command then fetches the three in-flight addresses again in their original order, oldest first. Fetch then continues at the remembered address, and a held delay-slot target is applied after it. Because replay follows the recorded addresses, a branch that is already captured in the history is repeated exactly.

Top module: `restart_pc_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the fetch address equals the RESET_PC parameter, and every history slot and the resume address read zero.
- R2: In normal running, a cycle with fetch enabled, no held target and no fault makes the fetch address one higher. The same cycle shifts the history: slot 0 (bits AW-1:0, the newest) takes the address just fetched, and slot k takes the old slot k-1. A cycle with fetch, fault and return all low changes neither the fetch address nor the history.
- R3: A branch strobe on a fetch cycle of address A, with no target held, makes the next fetch address A+1 (the delay slot). The fetch after that uses the branch target, and fetch then increments from the target.
- R4: A branch strobe that arrives while a target is held, or on a cycle without fetch, is ignored. The held target is still the one used.
- R5: A fault strobe makes the next fetch address equal the handler input and the resume address equal the address being fetched when the fault arrived. The history is left unchanged. A fault wins over a branch strobe and over a return command in the same cycle.
- R6: While the handler runs, fetches increment the address and branches work with one delay slot, but the history does not shift.
- R7: A return command in the handler starts a replay. The fetch addresses that follow are history slot 2, then slot 1, then slot 0, each taking one fetch, and then the resume address. Normal incrementing and history shifting continue after that. Recorded non-sequential addresses are replayed exactly as recorded.
- R8: If a target was held when the fault arrived, it is kept. After replay, the fetch of the resume address is followed by that target.
- R9: A return command outside the handler is ignored. Fetch behaves as it does when the command is low.
- R10: A fault during replay redirects fetch to the handler again, keeping the resume address and the history. A later return command replays from slot 2 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fetch_en_i | input | 1 | An instruction fetch happens this cycle |
| br_taken_i | input | 1 | Taken-branch strobe, sampled on fetch cycles |
| br_target_i | input | AW | Branch target word address |
| exc_i | input | 1 | Fault or interrupt strobe |
| handler_i | input | AW | Exception handler entry address |
| rfe_i | input | 1 | Return-from-exception command |
| fetch_pc_o | output | AW | Current fetch address |
| hist_o | output | HIST_DEPTH*AW | PC history, slot k at bits k*AW +: AW, slot 0 newest |
| resume_pc_o | output | AW | Fetch address saved at the fault |

## Verification
Plain sequential runs check the incrementing and the shifting of the history. Branch runs separate a correct single delay slot from a zero or two-slot delay, and a second strobe on the delay slot shows whether the one-entry target slot is protected. Fault runs use a history that holds a branch, so a replay that just counts upward gives the wrong order. A fault taken while a target is held shows whether that target is lost, and a fault during replay, plus return commands given outside the handler, check the mode transitions.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   typedef enum logic [1:0] {
      RPC_RUN    = 2'd0,
      RPC_TRAP   = 2'd1,
      RPC_REPLAY = 2'd2
   } rpc_mode_e;
endpackage

// File: rtl/rpc_hist.sv
module rpc_hist #(
   parameter int AW    = 32,
   parameter int DEPTH = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                push_i,
   input  logic [AW-1:0]       din_i,
   output logic [DEPTH*AW-1:0] hist_o
);
   logic [DEPTH*AW-1:0] slot_q;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_slot
         if (k == 0) begin : g_head
            always_ff @(posedge clk_i) begin
               if (!rst_ni)     slot_q[AW-1:0] <= '0;
               else if (push_i) slot_q[AW-1:0] <= din_i;
            end
         end else begin : g_tail
            always_ff @(posedge clk_i) begin
               if (!rst_ni)     slot_q[k*AW +: AW] <= '0;
               else if (push_i) slot_q[k*AW +: AW] <= slot_q[(k-1)*AW +: AW];
            end
         end
      end
   endgenerate

   assign hist_o = slot_q;
endmodule

// File: rtl/rpc_target.sv
module rpc_target #(
   parameter int AW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          set_i,
   input  logic [AW-1:0] set_tgt_i,
   input  logic          take_i,
   input  logic          clr_i,
   input  logic          restore_i,
   input  logic          capture_i,
   output logic          pend_v_o,
   output logic [AW-1:0] pend_tgt_o,
   output logic          sav_v_o,
   output logic [AW-1:0] sav_tgt_o
);
   logic          pend_v_q, sav_v_q;
   logic [AW-1:0] pend_tgt_q, sav_tgt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_v_q   <= 1'b0;
         pend_tgt_q <= '0;
      end else if (restore_i) begin
         pend_v_q   <= sav_v_q;
         pend_tgt_q <= sav_tgt_q;
      end else if (clr_i || take_i) begin
         pend_v_q   <= 1'b0;
      end else if (set_i) begin
         pend_v_q   <= 1'b1;
         pend_tgt_q <= set_tgt_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sav_v_q   <= 1'b0;
         sav_tgt_q <= '0;
      end else if (capture_i) begin
         sav_v_q   <= pend_v_q;
         sav_tgt_q <= pend_tgt_q;
      end
   end

   assign pend_v_o   = pend_v_q;
   assign pend_tgt_o = pend_tgt_q;
   assign sav_v_o    = sav_v_q;
   assign sav_tgt_o  = sav_tgt_q;
endmodule

// File: rtl/rpc_seq.sv
module rpc_seq
   import rpc_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int          DEPTH    = 4,
   parameter int          REPLAY_N = 3,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                fetch_en_i,
   input  logic                br_taken_i,
   input  logic                exc_i,
   input  logic [AW-1:0]       handler_i,
   input  logic                rfe_i,
   input  logic                pend_v_i,
   input  logic [AW-1:0]       pend_tgt_i,
   input  logic [DEPTH*AW-1:0] hist_i,
   output logic [AW-1:0]       pc_o,
   output logic [AW-1:0]       resume_o,
   output rpc_mode_e           mode_o,
   output logic                push_o,
   output logic                set_o,
   output logic                take_o,
   output logic                clr_o,
   output logic                restore_o,
   output logic                capture_o
);
   localparam int CW = (REPLAY_N < 2) ? 1 : $clog2(REPLAY_N + 1);

   rpc_mode_e     mode_q, mode_d;
   logic [AW-1:0] pc_q, pc_d, resume_q;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [AW-1:0] replay_pc;

   // select the history slot that follows the one now being replayed
   always_comb begin
      replay_pc = resume_q;
      for (int k = 0; k < REPLAY_N; k++) begin
         if (int'(cnt_q) == k + 1) replay_pc = hist_i[k*AW +: AW];
      end
   end

   always_comb begin
      pc_d      = pc_q;
      mode_d    = mode_q;
      cnt_d     = cnt_q;
      push_o    = 1'b0;
      set_o     = 1'b0;
      take_o    = 1'b0;
      clr_o     = 1'b0;
      restore_o = 1'b0;
      capture_o = 1'b0;
      if (exc_i) begin
         pc_d      = handler_i;
         clr_o     = 1'b1;
         capture_o = (mode_q == RPC_RUN);
         mode_d    = RPC_TRAP;
      end else begin
         unique case (mode_q)
            RPC_RUN, RPC_TRAP: begin
               if (mode_q == RPC_TRAP && rfe_i) begin
                  pc_d   = hist_i[(REPLAY_N-1)*AW +: AW];
                  clr_o  = 1'b1;
                  cnt_d  = CW'(REPLAY_N - 1);
                  mode_d = RPC_REPLAY;
               end else if (fetch_en_i) begin
                  push_o = (mode_q == RPC_RUN);
                  if (pend_v_i) begin
                     pc_d   = pend_tgt_i;
                     take_o = 1'b1;
                  end else begin
                     pc_d  = pc_q + AW'(1);
                     set_o = br_taken_i;
                  end
               end
            end
            RPC_REPLAY: begin
               if (fetch_en_i) begin
                  pc_d = replay_pc;
                  if (cnt_q != '0) begin
                     cnt_d = cnt_q - CW'(1);
                  end else begin
                     restore_o = 1'b1;
                     mode_d    = RPC_RUN;
                  end
               end
            end
            default: mode_d = RPC_RUN;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pc_q     <= RESET_PC;
         mode_q   <= RPC_RUN;
         cnt_q    <= '0;
         resume_q <= '0;
      end else begin
         pc_q   <= pc_d;
         mode_q <= mode_d;
         cnt_q  <= cnt_d;
         if (capture_o) resume_q <= pc_q;
      end
   end

   assign pc_o     = pc_q;
   assign resume_o = resume_q;
   assign mode_o   = mode_q;
endmodule

// File: rtl/restart_pc_unit.sv
module restart_pc_unit
   import rpc_pkg::*;
#(
   parameter int            AW         = 32,
   parameter int            HIST_DEPTH = 4,
   parameter int            REPLAY_N   = 3,
   parameter logic [AW-1:0] RESET_PC   = '0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     fetch_en_i,
   input  logic                     br_taken_i,
   input  logic [AW-1:0]            br_target_i,
   input  logic                     exc_i,
   input  logic [AW-1:0]            handler_i,
   input  logic                     rfe_i,
   output logic [AW-1:0]            fetch_pc_o,
   output logic [HIST_DEPTH*AW-1:0] hist_o,
   output logic [AW-1:0]            resume_pc_o
);
   generate
      if (AW < 2) begin : g_bad_aw
         $error("restart_pc_unit: AW must be at least 2");
      end
      if (REPLAY_N < 1) begin : g_bad_replay
         $error("restart_pc_unit: REPLAY_N must be at least 1");
      end
      if (HIST_DEPTH < REPLAY_N) begin : g_bad_depth
         $error("restart_pc_unit: HIST_DEPTH must cover REPLAY_N");
      end
   endgenerate

   rpc_mode_e     mode;
   logic          push, set, take, clr, restore, capture;
   logic          pend_v, sav_v;
   logic [AW-1:0] pend_tgt, sav_tgt;

   rpc_seq #(
      .AW(AW), .DEPTH(HIST_DEPTH), .REPLAY_N(REPLAY_N), .RESET_PC(RESET_PC)
   ) seq_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .fetch_en_i(fetch_en_i),
      .br_taken_i(br_taken_i), .exc_i(exc_i), .handler_i(handler_i),
      .rfe_i(rfe_i), .pend_v_i(pend_v), .pend_tgt_i(pend_tgt),
      .hist_i(hist_o), .pc_o(fetch_pc_o), .resume_o(resume_pc_o),
      .mode_o(mode), .push_o(push), .set_o(set), .take_o(take),
      .clr_o(clr), .restore_o(restore), .capture_o(capture)
   );

   rpc_target #(.AW(AW)) tgt_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .set_tgt_i(br_target_i),
      .take_i(take), .clr_i(clr), .restore_i(restore), .capture_i(capture),
      .pend_v_o(pend_v), .pend_tgt_o(pend_tgt),
      .sav_v_o(sav_v), .sav_tgt_o(sav_tgt)
   );

   rpc_hist #(.AW(AW), .DEPTH(HIST_DEPTH)) hist_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push),
      .din_i(fetch_pc_o), .hist_o(hist_o)
   );

   logic unused_sav;
   assign unused_sav = sav_v ^ (^sav_tgt);
endmodule

// File: rtl/restart_pc_unit_chk.sv
module restart_pc_unit_chk
   import rpc_pkg::*;
#(
   parameter int AW         = 32,
   parameter int HIST_DEPTH = 4,
   parameter int REPLAY_N   = 3
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     fetch_en_i,
   input logic                     exc_i,
   input logic                     rfe_i,
   input logic [AW-1:0]            handler_i,
   input logic [AW-1:0]            fetch_pc_o,
   input logic [HIST_DEPTH*AW-1:0] hist_o,
   input rpc_mode_e                mode,
   input logic                     pend_v,
   input logic [AW-1:0]            pend_tgt
);
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fetch_en_i && !exc_i && !rfe_i) |=> $stable(fetch_pc_o)); // R2

   AST_RUN_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == RPC_RUN && fetch_en_i && !exc_i && !pend_v)
      |=> fetch_pc_o == $past(fetch_pc_o) + AW'(1)); // R2

   AST_RUN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == RPC_RUN && fetch_en_i && !exc_i)
      |=> hist_o[AW-1:0] == $past(fetch_pc_o)); // R2

   AST_TARGET_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode != RPC_REPLAY && fetch_en_i && !exc_i && pend_v
       && !(mode == RPC_TRAP && rfe_i))
      |=> fetch_pc_o == $past(pend_tgt)); // R3

   AST_TRAP_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_i |=> fetch_pc_o == $past(handler_i)); // R5

   AST_HIST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_i || mode != RPC_RUN) |=> $stable(hist_o)); // R6

   AST_REPLAY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == RPC_TRAP && rfe_i && !exc_i)
      |=> fetch_pc_o == $past(hist_o[(REPLAY_N-1)*AW +: AW])); // R7
endmodule

bind restart_pc_unit restart_pc_unit_chk #(
   .AW(AW), .HIST_DEPTH(HIST_DEPTH), .REPLAY_N(REPLAY_N)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .fetch_en_i(fetch_en_i), .exc_i(exc_i),
   .rfe_i(rfe_i), .handler_i(handler_i), .fetch_pc_o(fetch_pc_o),
   .hist_o(hist_o), .mode(mode), .pend_v(pend_v), .pend_tgt(pend_tgt)
);

// File: tb/restart_pc_unit_tb_top.sv
`timescale 1ns/1ps
module restart_pc_unit_tb_top;
   localparam int          AW   = 32;
   localparam int          HD   = 4;
   localparam logic [31:0] RPC  = 32'h40;
   localparam logic [31:0] HNDL = 32'h800;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          fetch_en_i = 1'b0, br_taken_i = 1'b0, exc_i = 1'b0, rfe_i = 1'b0;
   logic [31:0]   br_target_i = '0;
   logic [31:0]   handler_i = HNDL;
   logic [31:0]   fetch_pc_o, resume_pc_o;
   logic [HD*AW-1:0] hist_o;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   restart_pc_unit #(.AW(AW), .HIST_DEPTH(HD), .REPLAY_N(3), .RESET_PC(RPC)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .fetch_en_i(fetch_en_i),
      .br_taken_i(br_taken_i), .br_target_i(br_target_i), .exc_i(exc_i),
      .handler_i(handler_i), .rfe_i(rfe_i), .fetch_pc_o(fetch_pc_o),
      .hist_o(hist_o), .resume_pc_o(resume_pc_o)
   );

   function automatic logic [31:0] h(input int k);
      return hist_o[k*AW +: AW];
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_hist(input string req, input logic [31:0] e0, e1, e2, e3);
      chk(req, "hist0", h(0), e0);
      chk(req, "hist1", h(1), e1);
      chk(req, "hist2", h(2), e2);
      chk(req, "hist3", h(3), e3);
   endtask

   // drive one cycle from a falling edge; outputs are checked at the next falling edge
   task automatic drive(input logic fe, input logic br, input logic [31:0] tgt, input logic ex, input logic rf);
      fetch_en_i = fe; br_taken_i = br; br_target_i = tgt; exc_i = ex; rfe_i = rf;
      @(negedge clk);
      fetch_en_i = 1'b0; br_taken_i = 1'b0; br_target_i = '0; exc_i = 1'b0; rfe_i = 1'b0;
   endtask

   task automatic fetch(input logic br, input logic [31:0] tgt);
      drive(1'b1, br, tgt, 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      repeat (2) @(negedge clk);
      rst_ni = 1'b1;
   endtask

   task automatic t_reset_and_seq();
      do_reset();
      chk("R1", "pc", fetch_pc_o, RPC);
      chk("R1", "resume", resume_pc_o, 32'h0);
      chk_hist("R1", 0, 0, 0, 0);
      for (int i = 0; i < 5; i++) fetch(1'b0, '0);
      chk("R2", "pc after 5", fetch_pc_o, 32'h45);
      chk_hist("R2", 32'h44, 32'h43, 32'h42, 32'h41);
      drive(1'b0, 1'b1, 32'h999, 1'b0, 1'b0);
      chk("R2", "idle pc", fetch_pc_o, 32'h45);
      chk_hist("R2", 32'h44, 32'h43, 32'h42, 32'h41);
      fetch(1'b0, '0);
      chk("R4", "strobe without fetch ignored", fetch_pc_o, 32'h46);
   endtask

   task automatic t_branch();
      do_reset();
      fetch(1'b1, 32'h100);
      chk("R3", "delay slot", fetch_pc_o, 32'h41);
      fetch(1'b1, 32'h500);
      chk("R3", "target", fetch_pc_o, 32'h100);
      fetch(1'b0, '0);
      chk("R4", "second strobe ignored", fetch_pc_o, 32'h101);
      fetch(1'b1, 32'h180);
      chk("R3", "next delay slot", fetch_pc_o, 32'h102);
      fetch(1'b0, '0);
      chk("R3", "next target", fetch_pc_o, 32'h180);
   endtask

   task automatic t_fault_replay();
      do_reset();
      fetch(1'b1, 32'h200);
      fetch(1'b0, '0);
      fetch(1'b0, '0);
      fetch(1'b0, '0);
      chk("R3", "pre-fault pc", fetch_pc_o, 32'h202);
      chk_hist("R2", 32'h201, 32'h200, 32'h41, 32'h40);
      drive(1'b1, 1'b1, 32'h999, 1'b1, 1'b1);
      chk("R5", "handler pc", fetch_pc_o, HNDL);
      chk("R5", "resume", resume_pc_o, 32'h202);
      chk_hist("R5", 32'h201, 32'h200, 32'h41, 32'h40);
      fetch(1'b1, 32'h900);
      chk("R6", "handler delay slot", fetch_pc_o, HNDL + 1);
      fetch(1'b0, '0);
      chk("R6", "handler target", fetch_pc_o, 32'h900);
      chk_hist("R6", 32'h201, 32'h200, 32'h41, 32'h40);
      drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk("R7", "replay 1", fetch_pc_o, 32'h41);
      fetch(1'b0, '0);
      chk("R7", "replay 2", fetch_pc_o, 32'h200);
      fetch(1'b0, '0);
      chk("R7", "replay 3", fetch_pc_o, 32'h201);
      fetch(1'b0, '0);
      chk("R7", "resume", fetch_pc_o, 32'h202);
      fetch(1'b0, '0);
      chk("R7", "after resume", fetch_pc_o, 32'h203);
      chk_hist("R7", 32'h202, 32'h201, 32'h200, 32'h41);
   endtask

   task automatic t_fault_pending();
      do_reset();
      fetch(1'b0, '0);
      fetch(1'b1, 32'h300);
      chk("R3", "delay slot", fetch_pc_o, 32'h42);
      drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
      chk("R5", "resume", resume_pc_o, 32'h42);
      drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk("R8", "replay 1", fetch_pc_o, 32'h0);
      fetch(1'b0, '0);
      fetch(1'b0, '0);
      chk("R8", "replay 3", fetch_pc_o, 32'h41);
      fetch(1'b0, '0);
      chk("R8", "resume slot", fetch_pc_o, 32'h42);
      fetch(1'b0, '0);
      chk("R8", "held target", fetch_pc_o, 32'h300);
      fetch(1'b0, '0);
      chk("R8", "after target", fetch_pc_o, 32'h301);
   endtask

   task automatic t_rfe_ignored();
      do_reset();
      fetch(1'b0, '0);
      fetch(1'b0, '0);
      drive(1'b1, 1'b0, '0, 1'b0, 1'b1);
      chk("R9", "fetch with rfe", fetch_pc_o, 32'h43);
      drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk("R9", "rfe alone", fetch_pc_o, 32'h43);
      chk_hist("R9", 32'h42, 32'h41, 32'h40, 32'h0);
   endtask

   task automatic t_fault_in_replay();
      do_reset();
      for (int i = 0; i < 4; i++) fetch(1'b0, '0);
      drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
      drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk("R10", "replay 1", fetch_pc_o, 32'h41);
      fetch(1'b0, '0);
      drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
      chk("R10", "handler again", fetch_pc_o, HNDL);
      chk("R10", "resume kept", resume_pc_o, 32'h44);
      chk_hist("R10", 32'h43, 32'h42, 32'h41, 32'h40);
      drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk("R10", "replay restart", fetch_pc_o, 32'h41);
      fetch(1'b0, '0);
      fetch(1'b0, '0);
      fetch(1'b0, '0);
      chk("R10", "resume", fetch_pc_o, 32'h44);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_and_seq();
      t_branch();
      t_fault_replay();
      t_fault_pending();
      t_rfe_ignored();
      t_fault_in_replay();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule